// File: doc/BRIEF.md
# Condition Code and Branch Resolver

This block keeps the four processor status flags (negative, zero, carry, overflow) for a 32-bit integer datapath and decides conditional branches. Every instruction presents its ALU result, carry and overflow together with a four-bit write mask. Only the flags whose mask bit is set are written at the clock edge. A shift therefore writes just the carry, and an instruction that should leave the flags alone drives an all-zero mask.

Branch resolution is combinational and works in one of three styles, chosen per instruction. The first style tests the stored flags. The second tests a boolean value that an earlier compare left in a general register. The third is a fused compare-and-branch, which compares two register operands directly and does not touch the flags. In every style the block also forms the PC-relative target from the current PC and a signed word offset. It then selects the next PC.

Top module: `cbr_resolver`

## Requirements
- R1: While rst_ni is low, and after it rises, flags_o reads 4'b0000 until the first write. flags_o bit order is {N, Z, C, V} from bit 3 down to bit 0.
- R2: At a rising clock edge, each flag whose flag_we_i bit is 1 takes its new value: N from alu_res_i[31], Z from (alu_res_i == 0), C from alu_carry_i and V from alu_ovf_i. The mask bit order matches flags_o.
- R3: A flag whose flag_we_i bit is 0 keeps its value. For example, a carry-only mask 4'b0010 leaves N, Z and V unchanged.
- R4: With br_kind_i = 1 (flag style), taken_o follows cond_i applied to the stored flags. The codes are EQ=0 (Z), NE=1 (!Z), GT=2 (!Z && N==V), LE=3 (!GT), LT=4 (N!=V) and GE=5 (!LT).
- R5: When a flag write and a flag-style branch fall in the same cycle, the branch tests the flags as they were before that write.
- R6: With br_kind_i = 2 (condition-register style), taken_o is 1 exactly when rs_a_i is nonzero, whatever cond_i is.
- R7: With br_kind_i = 3 (compare-and-branch), taken_o applies the same condition codes to the signed comparison of rs_a_i with rs_b_i. The stored flags are not changed by this comparison.
- R8: target_o equals pc_i + 4 + (sign-extended offset_i << 2) for the full 8-bit offset range, from -128 to +127 instructions.
- R9: br_kind_i = 0, or condition code 6 or 7, is never taken. Whenever taken_o is 0, next_pc_o is pc_i + 4; otherwise it is target_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_we_i | input | 4 | Per-flag write mask {N,Z,C,V} |
| alu_res_i | input | 32 | ALU result for N and Z |
| alu_carry_i | input | 1 | ALU carry out |
| alu_ovf_i | input | 1 | ALU signed overflow |
| br_kind_i | input | 2 | 0 none, 1 flags, 2 condition register, 3 compare-and-branch |
| cond_i | input | 3 | Condition code |
| rs_a_i | input | 32 | First register operand |
| rs_b_i | input | 32 | Second register operand |
| pc_i | input | 32 | Current PC |
| offset_i | input | 8 | Signed branch offset in instructions |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | PC-relative target |
| next_pc_o | output | 32 | Selected next PC |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The hardest cases to reach are the signed conditions whose answer depends on overflow, where N and V differ. In compare-and-branch this happens only when the operands have opposite signs and their difference wraps. In flag style it happens only when a write with V set is followed by a branch that tests those flags, often while yet another write lands in the same cycle. The stimulus therefore draws operands mostly from the extremes of the 32-bit range (0, ±1, the most positive and most negative values, and equal pairs). It pairs random write masks with flag-style branches on every cycle, and adds directed cases that wrap the subtraction and write the carry alone.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FLAG = 2'd1,
    KIND_CREG = 2'd2,
    KIND_CMP  = 2'd3
  } br_kind_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_GT = 3'd2,
    CC_LE = 3'd3,
    CC_LT = 3'd4,
    CC_GE = 3'd5
  } cond_e;

  localparam int unsigned FB_N = 3;
  localparam int unsigned FB_Z = 2;
  localparam int unsigned FB_C = 1;
  localparam int unsigned FB_V = 0;
  localparam int unsigned NFLAGS = 4;
endpackage

// File: rtl/cbr_flag_reg.sv
module cbr_flag_reg
  import cbr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] we_i,
  input  logic [W-1:0]      res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output logic [NFLAGS-1:0] flags_o
);
  logic [NFLAGS-1:0] nxt;

  always_comb begin
    nxt       = '0;
    nxt[FB_N] = res_i[W-1];
    nxt[FB_Z] = (res_i == '0);
    nxt[FB_C] = carry_i;
    nxt[FB_V] = ovf_i;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flags_o[i] <= 1'b0;
      else if (we_i[i]) flags_o[i] <= nxt[i];
    end

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[i] |=> $stable(flags_o[i])); // R3
  end

  AST_Z_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[FB_Z] |=> (flags_o[FB_Z] == ($past(res_i) == '0))); // R2
  AST_C_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[FB_C] |=> (flags_o[FB_C] == $past(carry_i))); // R2
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
(
  input  logic       n_i,
  input  logic       z_i,
  input  logic       v_i,
  input  logic [2:0] cond_i,
  output logic       hit_o
);
  logic gt, lt;

  assign lt = n_i ^ v_i;
  assign gt = !z_i && !lt;

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ:   hit_o = z_i;
      CC_NE:   hit_o = !z_i;
      CC_GT:   hit_o = gt;
      CC_LE:   hit_o = !gt;
      CC_LT:   hit_o = lt;
      CC_GE:   hit_o = !lt;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_cmp_unit.sv
module cbr_cmp_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o
);
  logic [W-1:0] diff;

  assign diff = a_i - b_i;
  assign n_o  = diff[W-1];
  assign z_o  = (a_i == b_i);
  // signed overflow of a - b: operand signs differ and result sign departs from a
  assign v_o  = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned INSN_B = 4
) (
  input  logic [W-1:0]     pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]     seq_pc_o,
  output logic [W-1:0]     tgt_o
);
  localparam int unsigned SH = $clog2(INSN_B);

  logic [W-1:0] off_ext;

  assign off_ext  = {{(W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign seq_pc_o = pc_i + W'(INSN_B);
  assign tgt_o    = seq_pc_o + (off_ext << SH);
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
  import cbr_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned OFF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] flag_we_i,
  input  logic [W-1:0]      alu_res_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  input  logic [1:0]        br_kind_i,
  input  logic [2:0]        cond_i,
  input  logic [W-1:0]      rs_a_i,
  input  logic [W-1:0]      rs_b_i,
  input  logic [W-1:0]      pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              taken_o,
  output logic [W-1:0]      target_o,
  output logic [W-1:0]      next_pc_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam int unsigned NSRC = 2; // 0: stored flags, 1: fused compare

  logic [NSRC-1:0] src_n, src_z, src_v, src_hit;
  logic [W-1:0]    seq_pc;
  logic            creg_true;

  cbr_flag_reg #(.W(W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .res_i  (alu_res_i),
    .carry_i(alu_carry_i),
    .ovf_i  (alu_ovf_i),
    .flags_o(flags_o)
  );

  // register-to-register compare, independent of stored flags
  cbr_cmp_unit #(.W(W)) u_cmp (
    .a_i(rs_a_i),
    .b_i(rs_b_i),
    .n_o(src_n[1]),
    .z_o(src_z[1]),
    .v_o(src_v[1])
  );

  assign src_n[0] = flags_o[FB_N];
  assign src_z[0] = flags_o[FB_Z];
  assign src_v[0] = flags_o[FB_V];

  for (genvar s = 0; s < NSRC; s++) begin : g_eval
    cbr_cond_eval u_eval (
      .n_i   (src_n[s]),
      .z_i   (src_z[s]),
      .v_i   (src_v[s]),
      .cond_i(cond_i),
      .hit_o (src_hit[s])
    );
  end

  assign creg_true = (rs_a_i != '0);

  always_comb begin
    unique case (br_kind_e'(br_kind_i))
      KIND_FLAG: taken_o = src_hit[0];
      KIND_CREG: taken_o = creg_true;
      KIND_CMP:  taken_o = src_hit[1];
      default:   taken_o = 1'b0;
    endcase
  end

  cbr_target_gen #(.W(W), .OFF_W(OFF_W), .INSN_B(4)) u_tgt (
    .pc_i    (pc_i),
    .off_i   (offset_i),
    .seq_pc_o(seq_pc),
    .tgt_o   (target_o)
  );

  assign next_pc_o = taken_o ? target_o : seq_pc;

  AST_NONE_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 2'd0) |-> !taken_o); // R9
  AST_FALLTHRU_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (next_pc_o == pc_i + W'(4))); // R9
  AST_CREG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 2'd2 && rs_a_i == '0) |-> !taken_o); // R6
  AST_CMP_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 2'd3 && cond_i == 3'd0 && rs_a_i == rs_b_i) |-> taken_o); // R7
  AST_FLAG_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 2'd1 && cond_i == 3'd0) |-> (taken_o == flags_o[FB_Z])); // R4
endmodule

// File: tb/cbr_resolver_tb.sv
`timescale 1ns/1ps
module cbr_resolver_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  flag_we_i = '0;
  logic [31:0] alu_res_i = '0;
  logic        alu_carry_i = 1'b0;
  logic        alu_ovf_i = 1'b0;
  logic [1:0]  br_kind_i = '0;
  logic [2:0]  cond_i = '0;
  logic [31:0] rs_a_i = '0, rs_b_i = '0, pc_i = '0;
  logic [7:0]  offset_i = '0;
  logic        taken_o;
  logic [31:0] target_o, next_pc_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] mflags = '0;
  logic [3:0] prev_mask = 4'hF;

  always #2.5 clk_i = ~clk_i;

  cbr_resolver u_dut (.*);

  function automatic bit ev(bit n, bit z, bit v, logic [2:0] c);
    bit lt = n ^ v;
    bit gt = !z && !lt;
    case (c)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return gt;
      3'd3: return !gt;
      3'd4: return lt;
      3'd5: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] k, logic [2:0] c, logic [3:0] m, logic [31:0] r,
                      bit cy, bit ov, logic [31:0] a, logic [31:0] b,
                      logic [31:0] pc, logic [7:0] off);
    logic [31:0] d, exp_tgt, exp_seq;
    bit exp_tk;
    string tag;
    @(negedge clk_i);
    br_kind_i = k; cond_i = c; flag_we_i = m; alu_res_i = r;
    alu_carry_i = cy; alu_ovf_i = ov; rs_a_i = a; rs_b_i = b; pc_i = pc; offset_i = off;
    #1;
    d = a - b;
    case (k)
      2'd1: exp_tk = ev(mflags[3], mflags[2], mflags[0], c);
      2'd2: exp_tk = (a != 0);
      2'd3: exp_tk = ev(d[31], a == b, (a[31] ^ b[31]) & (d[31] ^ a[31]), c);
      default: exp_tk = 0;
    endcase
    if (k == 2'd1) tag = (m != 0) ? "R5" : "R4";
    else if (k == 2'd2) tag = "R6";
    else if (k == 2'd3) tag = "R7";
    else tag = "R9";
    if (c > 3'd5 && k != 2'd2) tag = "R9";
    chk(taken_o == exp_tk, tag, {31'd0, taken_o}, {31'd0, exp_tk});
    exp_seq = pc + 32'd4;
    exp_tgt = exp_seq + ({{24{off[7]}}, off} << 2);
    chk(target_o == exp_tgt, "R8", target_o, exp_tgt);
    chk(next_pc_o == (exp_tk ? exp_tgt : exp_seq), "R9", next_pc_o, exp_tk ? exp_tgt : exp_seq);
    chk(flags_o == mflags, (prev_mask == 4'hF) ? "R2" : "R3", {28'd0, flags_o}, {28'd0, mflags});
    if (m[3]) mflags[3] = r[31];
    if (m[2]) mflags[2] = (r == 0);
    if (m[1]) mflags[1] = cy;
    if (m[0]) mflags[0] = ov;
    prev_mask = m;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #7;
    chk(flags_o == 4'b0000, "R1", {28'd0, flags_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    #1 chk(flags_o == 4'b0000, "R1", {28'd0, flags_o}, 32'd0);

    // R2 full write: negative nonzero result, carry and overflow set
    step(2'd0, 3'd0, 4'hF, 32'h8000_0000, 1, 1, 0, 0, 32'h100, 8'h00);
    // R3 carry-only write from a shift; R4 LT from N!=V? N=1,V=1 -> GE
    step(2'd1, 3'd5, 4'b0010, 32'h0, 0, 0, 0, 0, 32'h200, 8'h7F);
    // R5 flag-style branch while all flags rewritten: sees old Z=0
    step(2'd1, 3'd0, 4'hF, 32'h0, 0, 0, 0, 0, 32'h300, 8'h80);
    step(2'd1, 3'd0, 4'h0, 32'h5, 0, 0, 0, 0, 32'h300, 8'h80);
    // R7 overflow compare: most negative vs 1 -> LT taken, GT not
    step(2'd3, 3'd4, 4'h0, 0, 0, 0, 32'h8000_0000, 32'h1, 32'h400, 8'h10);
    step(2'd3, 3'd2, 4'h0, 0, 0, 0, 32'h8000_0000, 32'h1, 32'h400, 8'h10);
    step(2'd3, 3'd2, 4'h0, 0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h400, 8'hF0);
    step(2'd3, 3'd0, 4'h0, 0, 0, 0, 32'h1234, 32'h1234, 32'h400, 8'h01);
    // R6 condition register ignores cond
    step(2'd2, 3'd7, 4'h0, 0, 0, 0, 32'h8, 0, 32'h500, 8'h02);
    step(2'd2, 3'd0, 4'h0, 0, 0, 0, 32'h0, 0, 32'h500, 8'h02);
    // R9 unused condition codes never taken
    step(2'd3, 3'd6, 4'h0, 0, 0, 0, 32'h5, 32'h5, 32'h600, 8'h03);
    step(2'd1, 3'd7, 4'h0, 0, 0, 0, 0, 0, 32'h600, 8'h03);
    // R8 wrap around address top
    step(2'd2, 3'd0, 4'h0, 0, 0, 0, 32'h1, 0, 32'hFFFF_FFFC, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = pick();
      b = ($urandom % 4 == 0) ? a : pick();
      step(2'($urandom), 3'($urandom % 8), 4'($urandom), pick(), 1'($urandom),
           1'($urandom), a, b, $urandom & 32'hFFFF_FFFC, 8'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule